// File: doc/BRIEF.md
# Pipelined Bilinear Texel Filter

This block turns a 2x2 neighbourhood of ARGB texels and a fractional sample position into one filtered ARGB pixel. A shader datapath feeds it the four texels surrounding a sample point together with the sub-texel offsets in x and y. Three clocks later the blended pixel comes out with its own valid strobe. The datapath is fully pipelined, so a new sample can enter on every clock. Bubbles are allowed anywhere in the input stream.

Each 8-bit colour channel is filtered on its own. The two texel rows are first blended along x. The two row results are then blended along y. The sum is kept at full precision until the last stage, where it is rounded to the nearest integer and limited to the channel range. A weight of exactly 1.0 can be expressed, so the filter reaches every corner texel exactly.

Top module: `bilerp_texel_filter`

## Requirements
- R1: The texel inputs are, in order, the base texel (N,M), its x neighbour (N+1,M), its y neighbour (N,M+1) and the diagonal (N+1,M+1). `frac_x` weights the x neighbours and `frac_y` weights the y row. With weights (1.0,0), (0,1.0) and (1.0,1.0), the output equals `texel_10`, `texel_01` and `texel_11` respectively.
- R2: Each fraction is a 9-bit unsigned fixed-point value with 8 fraction bits, so 0 means 0.0 and 256 means 1.0. Any value from 257 to 511 acts exactly as 256.
- R3: Per channel, with weights x, y in 0..256, the two row blends are `top = a*(256-x) + b*x` and `bot = c*(256-x) + d*x`. The output is `(top*(256-y) + bot*y + 32768) >> 16`, limited to 255.
- R4: Pixels are packed as A in bits 31:24, R in 23:16, G in 15:8 and B in 7:0. Each output lane depends only on the same lane of the four texels.
- R5: `out_valid` rises exactly three clocks after the edge that accepts an `in_valid` sample, and stays high for one clock per sample.
- R6: A new sample is accepted on every clock with `in_valid` high. Every accepted sample produces exactly one output, in issue order.
- R7: With both fractions 0, the output equals `texel_00` bit for bit.
- R8: While reset is asserted, and afterwards until the first result, `out_valid` and `out_pixel` are 0. Samples presented during reset are discarded.
- R9: While `out_valid` is low, `out_pixel` holds the last result. Inputs offered with `in_valid` low have no effect on later results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| texel_00 | input | 32 | Texel at (N,M), ARGB |
| texel_10 | input | 32 | Texel at (N+1,M), ARGB |
| texel_01 | input | 32 | Texel at (N,M+1), ARGB |
| texel_11 | input | 32 | Texel at (N+1,M+1), ARGB |
| frac_x | input | 9 | Horizontal weight, 256 = 1.0 |
| frac_y | input | 9 | Vertical weight, 256 = 1.0 |
| out_valid | output | 1 | Result strobe |
| out_pixel | output | 32 | Filtered ARGB pixel |

## Verification
The checker's properties take for granted that `in_valid` and the sample inputs are known, non-X values on every clock after reset. They also assume the weights and texels of a sample are presented on the same edge as its strobe. The stimulus changes inputs only half a period away from the active edge and drives defined values even during bubbles. It sweeps the weights across 0, 1.0, values just around 0.5 and 1.0, and out-of-range codes above 256, so the exact-corner and uniform-texel properties are reached many times.

// File: rtl/bilerp_pkg.sv
package bilerp_pkg;
   localparam int CH_W_DEF   = 8;
   localparam int FRAC_W_DEF = 8;
   localparam int N_CH_DEF   = 4;
   localparam int LATENCY    = 3;
endpackage

// File: rtl/bilerp_mix.sv
// Two-point linear blend at full precision: lo*(1-w) + hi*w, with w in 0..1.0.
module bilerp_mix #(
   parameter int IN_W   = 8,
   parameter int FRAC_W = 8,
   localparam int OUT_W = IN_W + FRAC_W
) (
   input  logic [IN_W-1:0]   lo,
   input  logic [IN_W-1:0]   hi,
   input  logic [FRAC_W:0]   wt,
   output logic [OUT_W-1:0]  mix
);
   localparam logic [FRAC_W:0] ONE = {1'b1, {FRAC_W{1'b0}}};

   if (IN_W < 1) begin : g_bad_in_w
      $error("bilerp_mix: IN_W must be positive");
   end
   if (FRAC_W < 1) begin : g_bad_frac_w
      $error("bilerp_mix: FRAC_W must be positive");
   end

   logic [FRAC_W:0] inv;

   assign inv = ONE - wt;
   assign mix = OUT_W'(lo) * OUT_W'(inv) + OUT_W'(hi) * OUT_W'(wt);
endmodule

// File: rtl/bilerp_round_sat.sv
// Round-half-up right shift followed by saturation to OUT_W bits.
module bilerp_round_sat #(
   parameter int IN_W  = 24,
   parameter int SHIFT = 16,
   parameter int OUT_W = 8
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   localparam int SW = IN_W + 1;
   localparam int QW = SW - SHIFT;
   localparam logic [SW-1:0] HALF = SW'(1) << (SHIFT - 1);
   localparam logic [OUT_W-1:0] MAXV = {OUT_W{1'b1}};

   if (SHIFT < 1) begin : g_bad_shift
      $error("bilerp_round_sat: SHIFT must be positive");
   end
   if (QW < OUT_W) begin : g_bad_width
      $error("bilerp_round_sat: input too narrow for output");
   end

   logic [SW-1:0] biased;
   logic [SW-1:0] shifted;

   assign biased  = SW'(din) + HALF;
   assign shifted = biased >> SHIFT;

   if (QW > OUT_W) begin : g_clamp
      assign dout = (shifted > SW'(MAXV)) ? MAXV : shifted[OUT_W-1:0];
   end else begin : g_direct
      assign dout = shifted[OUT_W-1:0];
   end
endmodule

// File: rtl/bilerp_texel_filter.sv
// Three-stage bilinear filter: row blends, column blend, round and limit.
module bilerp_texel_filter #(
   parameter int CH_W   = bilerp_pkg::CH_W_DEF,
   parameter int FRAC_W = bilerp_pkg::FRAC_W_DEF,
   parameter int N_CH   = bilerp_pkg::N_CH_DEF,
   localparam int PIX_W = CH_W * N_CH,
   localparam int FW    = FRAC_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [PIX_W-1:0]  texel_00,
   input  logic [PIX_W-1:0]  texel_10,
   input  logic [PIX_W-1:0]  texel_01,
   input  logic [PIX_W-1:0]  texel_11,
   input  logic [FW-1:0]     frac_x,
   input  logic [FW-1:0]     frac_y,
   output logic              out_valid,
   output logic [PIX_W-1:0]  out_pixel
);
   localparam int HW  = CH_W + FRAC_W;       // row blend width
   localparam int VW  = HW + FRAC_W;         // column blend width
   localparam int LAT = bilerp_pkg::LATENCY;
   localparam logic [FW-1:0] ONE = {1'b1, {FRAC_W{1'b0}}};

   if (CH_W < 1 || N_CH < 1) begin : g_bad_geom
      $error("bilerp_texel_filter: CH_W and N_CH must be positive");
   end
   if (FRAC_W < 1 || FRAC_W > 16) begin : g_bad_frac
      $error("bilerp_texel_filter: FRAC_W out of range");
   end
   if (LAT != 3) begin : g_bad_lat
      $error("bilerp_texel_filter: pipeline is built for three stages");
   end

   // weights above 1.0 act as 1.0
   logic [FW-1:0] wx_sat;
   logic [FW-1:0] wy_sat;

   assign wx_sat = (frac_x > ONE) ? ONE : frac_x;
   assign wy_sat = (frac_y > ONE) ? ONE : frac_y;

   logic [LAT-1:0]              vld_q;
   logic [N_CH-1:0][HW-1:0]     row0_c, row1_c, row0_q, row1_q;
   logic [FW-1:0]               wy_q;
   logic [N_CH-1:0][VW-1:0]     col_c, col_q;
   logic [N_CH-1:0][CH_W-1:0]   pix_c, pix_q;

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
      bilerp_mix #(.IN_W(CH_W), .FRAC_W(FRAC_W)) u_row0 (
         .lo  (texel_00[ch*CH_W +: CH_W]),
         .hi  (texel_10[ch*CH_W +: CH_W]),
         .wt  (wx_sat),
         .mix (row0_c[ch])
      );
      bilerp_mix #(.IN_W(CH_W), .FRAC_W(FRAC_W)) u_row1 (
         .lo  (texel_01[ch*CH_W +: CH_W]),
         .hi  (texel_11[ch*CH_W +: CH_W]),
         .wt  (wx_sat),
         .mix (row1_c[ch])
      );
      bilerp_mix #(.IN_W(HW), .FRAC_W(FRAC_W)) u_col (
         .lo  (row0_q[ch]),
         .hi  (row1_q[ch]),
         .wt  (wy_q),
         .mix (col_c[ch])
      );
      bilerp_round_sat #(.IN_W(VW), .SHIFT(2*FRAC_W), .OUT_W(CH_W)) u_rnd (
         .din  (col_q[ch]),
         .dout (pix_c[ch])
      );
   end

   // stage 1: row blends
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row0_q <= '0;
         row1_q <= '0;
         wy_q   <= '0;
      end else if (in_valid) begin
         row0_q <= row0_c;
         row1_q <= row1_c;
         wy_q   <= wy_sat;
      end
   end

   // stage 2: column blend
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
      end else if (vld_q[0]) begin
         col_q <= col_c;
      end
   end

   // stage 3: round and limit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q <= '0;
      end else if (vld_q[1]) begin
         pix_q <= pix_c;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         vld_q <= {vld_q[LAT-2:0], in_valid};
      end
   end

   assign out_valid = vld_q[LAT-1];
   assign out_pixel = pix_q;
endmodule

// File: rtl/bilerp_texel_filter_chk.sv
module bilerp_texel_filter_chk #(
   parameter int PIX_W = 32,
   parameter int FW    = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [PIX_W-1:0] texel_00,
   input logic [PIX_W-1:0] texel_10,
   input logic [PIX_W-1:0] texel_01,
   input logic [PIX_W-1:0] texel_11,
   input logic [FW-1:0]    frac_x,
   input logic [FW-1:0]    frac_y,
   input logic             out_valid,
   input logic [PIX_W-1:0] out_pixel
);
   localparam logic [FW-1:0] ONE = {1'b1, {(FW-1){1'b0}}};

   // edges since reset release, saturating at 3
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   logic warm;
   assign warm = (since_rst == 2'd3);

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (out_valid == $past(in_valid, 3))); // R5

   AST_ORIGIN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(in_valid, 3) && $past(frac_x, 3) == '0 && $past(frac_y, 3) == '0)
      |-> (out_pixel == $past(texel_00, 3))); // R7

   AST_X_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(in_valid, 3) && $past(frac_x, 3) >= ONE && $past(frac_y, 3) == '0)
      |-> (out_pixel == $past(texel_10, 3))); // R1

   AST_Y_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(in_valid, 3) && $past(frac_x, 3) == '0 && $past(frac_y, 3) >= ONE)
      |-> (out_pixel == $past(texel_01, 3))); // R2

   AST_UNIFORM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(in_valid, 3) && $past(texel_00, 3) == $past(texel_10, 3)
       && $past(texel_00, 3) == $past(texel_01, 3) && $past(texel_00, 3) == $past(texel_11, 3))
      |-> (out_pixel == $past(texel_00, 3))); // R3

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_pixel)); // R9
endmodule

bind bilerp_texel_filter bilerp_texel_filter_chk #(.PIX_W(PIX_W), .FW(FW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .texel_00  (texel_00),
   .texel_10  (texel_10),
   .texel_01  (texel_01),
   .texel_11  (texel_11),
   .frac_x    (frac_x),
   .frac_y    (frac_y),
   .out_valid (out_valid),
   .out_pixel (out_pixel)
);

// File: tb/bilerp_texel_filter_tb_top.sv
`timescale 1ns/1ps
module bilerp_texel_filter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] texel_00, texel_10, texel_01, texel_11;
   logic [8:0]  frac_x, frac_y;
   logic        out_valid;
   logic [31:0] out_pixel;

   always #5 clk = ~clk;

   bilerp_texel_filter dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .texel_00(texel_00), .texel_10(texel_10), .texel_01(texel_01), .texel_11(texel_11),
      .frac_x(frac_x), .frac_y(frac_y), .out_valid(out_valid), .out_pixel(out_pixel)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [31:0] exp_mem [0:1023];
   string       exp_tag [0:1023];
   int          wr_idx = 0;
   int          rd_idx = 0;
   bit          mon_en = 1'b0;
   logic [31:0] last_pix = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_px(input logic [31:0] a, b, c, d, input int fx, input int fy);
      logic [31:0] res;
      int x, y;
      x = (fx > 256) ? 256 : fx;
      y = (fy > 256) ? 256 : fy;
      res = '0;
      for (int ch = 0; ch < 4; ch++) begin
         int ta, tb, tc, td, top, bot, v, r;
         ta = int'(a[8*ch +: 8]); tb = int'(b[8*ch +: 8]);
         tc = int'(c[8*ch +: 8]); td = int'(d[8*ch +: 8]);
         top = ta * (256 - x) + tb * x;
         bot = tc * (256 - x) + td * x;
         v = top * (256 - y) + bot * y;
         r = (v + 32768) >>> 16;
         if (r > 255) r = 255;
         res[8*ch +: 8] = 8'(r);
      end
      return res;
   endfunction

   function automatic int frac_of(input int i);
      case (i)
         0: return 0;    1: return 1;    2: return 2;    3: return 64;
         4: return 127;  5: return 128;  6: return 129;  7: return 200;
         8: return 255;  9: return 256;  10: return 257; default: return 511;
      endcase
   endfunction

   function automatic logic [31:0] tex_of(input int p, input int k);
      if (p == 0) begin
         case (k)
            0: return 32'hFF00FF00;
            1: return 32'h00FF00FF;
            2: return 32'hFFFF0000;
            default: return 32'h0000FFFF;
         endcase
      end
      return {8'(p*37 + k*59 + 11), 8'(p*91 + k*13 + 200), 8'(p*17 + k*101 + 3), 8'(p*53 + k*7 + 129)};
   endfunction

   // output monitor, away from the active edge
   always @(negedge clk) begin
      if (mon_en && rst_n) begin
         if (out_valid) begin
            chk(out_pixel === exp_mem[rd_idx], exp_tag[rd_idx], out_pixel, exp_mem[rd_idx]);
            last_pix = out_pixel;
            rd_idx++;
         end else begin
            chk(out_pixel === last_pix, "R9 hold", out_pixel, last_pix);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", rd_idx, wr_idx);
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      in_valid = 1'b1;
      texel_00 = 32'hDEADBEEF; texel_10 = 32'h12345678;
      texel_01 = 32'h9ABCDEF0; texel_11 = 32'h0F0F0F0F;
      frac_x = 9'd100; frac_y = 9'd30;
      repeat (3) @(negedge clk);
      chk(out_valid === 1'b0, "R8 valid in reset", 32'(out_valid), 0);
      chk(out_pixel === 32'h0, "R8 pixel in reset", out_pixel, 0);
      rst_n = 1'b1;
      in_valid = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(out_valid === 1'b0 && out_pixel === 32'h0, "R8 after reset",
             {out_valid, out_pixel[30:0]}, 0);
      end

      // single sample latency
      texel_00 = 32'h11223344; frac_x = 9'd0; frac_y = 9'd0;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid === 1'b0, "R5 cycle1", 32'(out_valid), 0);
      @(negedge clk);
      chk(out_valid === 1'b0, "R5 cycle2", 32'(out_valid), 0);
      @(negedge clk);
      chk(out_valid === 1'b1, "R5 cycle3", 32'(out_valid), 1);
      chk(out_pixel === 32'h11223344, "R7 origin", out_pixel, 32'h11223344);
      last_pix = out_pixel;
      @(negedge clk);
      chk(out_valid === 1'b0, "R5 single strobe", 32'(out_valid), 0);

      // sweep, mostly back to back, with bubbles carrying junk
      mon_en = 1'b1;
      for (int p = 0; p < 4; p++) begin
         for (int ix = 0; ix < 12; ix++) begin
            for (int iy = 0; iy < 12; iy++) begin
               int fx, fy;
               fx = frac_of(ix);
               fy = frac_of(iy);
               texel_00 = tex_of(p, 0); texel_10 = tex_of(p, 1);
               texel_01 = tex_of(p, 2); texel_11 = tex_of(p, 3);
               frac_x = 9'(fx); frac_y = 9'(fy);
               in_valid = 1'b1;
               exp_mem[wr_idx] = ref_px(texel_00, texel_10, texel_01, texel_11, fx, fy);
               if (fx == 0 && fy == 0)
                  exp_tag[wr_idx] = "R7 origin";
               else if (fx > 256 || fy > 256)
                  exp_tag[wr_idx] = "R2 weight above one";
               else if ((fx == 0 || fx == 256) && (fy == 0 || fy == 256))
                  exp_tag[wr_idx] = "R1 corner";
               else if (p == 0)
                  exp_tag[wr_idx] = "R4 lane isolation";
               else
                  exp_tag[wr_idx] = "R3 blend";
               wr_idx++;
               @(negedge clk);
               if ((wr_idx % 7) == 0) begin
                  in_valid = 1'b0;
                  texel_00 = 32'hA5A5A5A5; texel_10 = 32'h5A5A5A5A;
                  texel_01 = 32'hC3C3C3C3; texel_11 = 32'h3C3C3C3C;
                  frac_x = 9'd77; frac_y = 9'd177;
                  @(negedge clk);
               end
            end
         end
      end
      in_valid = 1'b0;
      repeat (6) @(negedge clk);
      chk(rd_idx == wr_idx, "R6 one output per sample", 32'(rd_idx), 32'(wr_idx));
      finish_run();
   end
endmodule